// File: doc/BRIEF.md
# Emulated Dirty and Use Bit Tracker with Refill Permission Control

This block stands between a software-refilled TLB and the replacement logic of a paging system whose TLB has no hardware-maintained dirty or referenced bits. It keeps a small per-frame table holding three bits for every physical frame: modified, recently used, and the page's true write permission. From these bits it decides the write permission of every TLB entry it refills. A clean page always enters the TLB read-only, so the first store to it traps as a write fault. The block then records the page as dirty and upgrades the entry, and the access can be retried.

A compact TLB model with a few slots is part of the block. The refill handler names the slot to fill, and the block writes the frame number, the valid bit and the chosen permission into it. Writeback logic can clear a frame's modified bit, and a replacement sweeper can clear its used bit. Each clear also acts on every TLB slot that maps that frame. Clearing the modified bit makes matching slots read-only, and clearing the used bit invalidates them, so the next access to the frame is caught again.

Dropping a TLB slot raises no event, so the used bit only records miss-time recency and is approximate. The modified bit is exact: it rises only on a store event. Page table walks, disk traffic and memory contents are outside the block.

Top module: `cmTrack`

## Requirements
- R1: After reset, all modified, used and TLB valid and permission bits are 0, and none of respValid, respRw or respProtErr is asserted.
- R2: A read miss (evtOp = 1) on frame F into slot S sets used[F] and records the true write permission evtWritable for F. It loads slot S valid with frame F, and makes the slot read-write only if F was already modified and evtWritable is 1. One cycle later respValid = 1 and respRw equals that permission.
- R3: A write miss (evtOp = 2) with evtWritable = 1 sets modified[F] and used[F] and loads slot S read-write. One cycle later respValid = 1 and respRw = 1.
- R4: A write miss with evtWritable = 0 changes no state. One cycle later respProtErr = 1 and respValid = 0.
- R5: A write fault (evtOp = 3) on a valid read-only slot S whose frame is recorded as writable sets that frame's modified and used bits and makes slot S read-write. One cycle later respValid = 1 and respRw = 1.
- R6: A write fault on a valid read-only slot whose frame is recorded as not writable changes no state. One cycle later respProtErr = 1.
- R7: A write fault on an invalid slot, or on a slot that is already read-write, has no effect, and no response is raised.
- R8: A clear-modified command for frame F resets modified[F] and makes every slot mapping F read-only. Valid bits are unchanged.
- R9: A clear-used command for frame F resets used[F] and invalidates every slot mapping F.
- R10: If a miss or fault event resolves to the same frame as a clear command in the same cycle, that clear is dropped and the event's update stands. A clear naming a different frame still takes effect. Clears act before the event on the TLB slots.
- R11: A modified bit never rises in a cycle after which no write miss or write fault was presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| evtOp | input | 2 | Event: 0 none, 1 read miss, 2 write miss, 3 write fault |
| evtFrame | input | FW | Frame of a miss event |
| evtSlot | input | SW | TLB slot to fill (miss) or that faulted (fault) |
| evtWritable | input | 1 | True write permission of the page on a miss |
| clrModValid | input | 1 | Clear-modified command strobe |
| clrModFrame | input | FW | Frame whose modified bit is cleared |
| clrUseValid | input | 1 | Clear-used command strobe |
| clrUseFrame | input | FW | Frame whose used bit is cleared |
| respValid | output | 1 | Entry loaded or upgraded in the previous cycle |
| respRw | output | 1 | Permission of that entry, 1 = read-write |
| respProtErr | output | 1 | Previous event was a true protection violation |
| modBits | output | FRAMES | Modified bit per frame |
| useBits | output | FRAMES | Used bit per frame |
| tlbValid | output | ENTRIES | Valid bit per TLB slot |
| tlbRw | output | ENTRIES | Write permission per TLB slot |

## Verification
The bench builds the block with its defaults of eight frames and four slots. Every frame then shares a slot with another frame, so refills overwrite live slots and a single clear must find its frame in the slot set. The bench sweeps both miss kinds over every frame, with alternating true permissions. It then drives faults on upgraded, read-only, truly protected and invalid slots, runs clears over all frames, and presents same-frame and different-frame collisions between misses and clears. Expected values come from an arithmetic model of the rules above.

// File: rtl/cmPkg.sv
package cmPkg;
  typedef enum logic [1:0] {
    OP_NONE   = 2'd0,
    OP_RMISS  = 2'd1,
    OP_WMISS  = 2'd2,
    OP_WFAULT = 2'd3
  } cmOp_e;

  typedef struct packed {
    logic setUse;
    logic setMod;
    logic recordWr;
    logic loadEntry;
    logic loadRw;
    logic upgrade;
    logic clrModEn;
    logic clrUseEn;
    logic respValid;
    logic respRw;
    logic protErr;
  } cmStrobe_t;
endpackage

// File: rtl/cmCtrl.sv
module cmCtrl
  import cmPkg::*;
(
  input  cmOp_e     op,
  input  logic      evtWritable,
  input  logic      curMod,
  input  logic      curWr,
  input  logic      slotValid,
  input  logic      slotRw,
  input  logic      clrModValid,
  input  logic      clrUseValid,
  input  logic      clrModSame,
  input  logic      clrUseSame,
  output cmStrobe_t st
);
  logic active;
  assign active = (op != OP_NONE);

  always_comb begin
    st = '0;
    case (op)
      OP_RMISS: begin
        st.setUse    = 1'b1;
        st.recordWr  = 1'b1;
        st.loadEntry = 1'b1;
        st.loadRw    = evtWritable & curMod;
        st.respValid = 1'b1;
        st.respRw    = evtWritable & curMod;
      end
      OP_WMISS: begin
        if (evtWritable) begin
          st.setUse    = 1'b1;
          st.setMod    = 1'b1;
          st.recordWr  = 1'b1;
          st.loadEntry = 1'b1;
          st.loadRw    = 1'b1;
          st.respValid = 1'b1;
          st.respRw    = 1'b1;
        end else begin
          st.protErr = 1'b1;
        end
      end
      OP_WFAULT: begin
        if (slotValid && !slotRw) begin
          if (curWr) begin
            st.setUse    = 1'b1;
            st.setMod    = 1'b1;
            st.upgrade   = 1'b1;
            st.respValid = 1'b1;
            st.respRw    = 1'b1;
          end else begin
            st.protErr = 1'b1;
          end
        end
      end
      default: ;
    endcase
    st.clrModEn = clrModValid && !(active && clrModSame);
    st.clrUseEn = clrUseValid && !(active && clrUseSame);
  end
endmodule

// File: rtl/cmData.sv
module cmData
  import cmPkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int ENTRIES = 4,
  localparam int FW = $clog2(FRAMES),
  localparam int SW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  cmOp_e              op,
  input  logic [FW-1:0]      evtFrame,
  input  logic [SW-1:0]      evtSlot,
  input  logic               evtWritable,
  input  logic [FW-1:0]      clrModFrame,
  input  logic [FW-1:0]      clrUseFrame,
  input  cmStrobe_t          st,
  output logic               curMod,
  output logic               curWr,
  output logic               slotValid,
  output logic               slotRw,
  output logic               clrModSame,
  output logic               clrUseSame,
  output logic               respValid,
  output logic               respRw,
  output logic               respProtErr,
  output logic [FRAMES-1:0]  modBits,
  output logic [FRAMES-1:0]  useBits,
  output logic [ENTRIES-1:0] tlbValid,
  output logic [ENTRIES-1:0] tlbRw
);
  logic [FRAMES-1:0]  modQ, useQ, wrQ;
  logic [ENTRIES-1:0] tlbVQ, tlbRwQ;
  logic [FW-1:0]      tlbFQ [ENTRIES];
  logic [FW-1:0]      effFrame;

  assign effFrame   = (op == OP_WFAULT) ? tlbFQ[evtSlot] : evtFrame;
  assign curMod     = modQ[effFrame];
  assign curWr      = wrQ[effFrame];
  assign slotValid  = tlbVQ[evtSlot];
  assign slotRw     = tlbRwQ[evtSlot];
  assign clrModSame = (clrModFrame == effFrame);
  assign clrUseSame = (clrUseFrame == effFrame);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modQ <= '0;
      useQ <= '0;
      wrQ  <= '0;
    end else begin
      for (int i = 0; i < FRAMES; i++) begin
        if (st.clrModEn && clrModFrame == FW'(i)) modQ[i] <= 1'b0;
        if (st.clrUseEn && clrUseFrame == FW'(i)) useQ[i] <= 1'b0;
        if (effFrame == FW'(i)) begin
          if (st.setMod)   modQ[i] <= 1'b1;
          if (st.setUse)   useQ[i] <= 1'b1;
          if (st.recordWr) wrQ[i]  <= evtWritable;
        end
      end
    end
  end

  generate
    for (genvar e = 0; e < ENTRIES; e++) begin : gSlot
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          tlbVQ[e]  <= 1'b0;
          tlbRwQ[e] <= 1'b0;
          tlbFQ[e]  <= '0;
        end else begin
          if (st.clrModEn && tlbFQ[e] == clrModFrame) tlbRwQ[e] <= 1'b0;
          if (st.clrUseEn && tlbFQ[e] == clrUseFrame) tlbVQ[e]  <= 1'b0;
          if (st.loadEntry && evtSlot == SW'(e)) begin
            tlbVQ[e]  <= 1'b1;
            tlbFQ[e]  <= evtFrame;
            tlbRwQ[e] <= st.loadRw;
          end
          if (st.upgrade && evtSlot == SW'(e)) tlbRwQ[e] <= 1'b1;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      respValid   <= 1'b0;
      respRw      <= 1'b0;
      respProtErr <= 1'b0;
    end else begin
      respValid   <= st.respValid;
      respRw      <= st.respRw;
      respProtErr <= st.protErr;
    end
  end

  assign modBits  = modQ;
  assign useBits  = useQ;
  assign tlbValid = tlbVQ;
  assign tlbRw    = tlbRwQ;
endmodule

// File: rtl/cmTrack.sv
module cmTrack
  import cmPkg::*;
#(
  parameter int FRAMES  = 8,
  parameter int ENTRIES = 4,
  localparam int FW = $clog2(FRAMES),
  localparam int SW = $clog2(ENTRIES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [1:0]         evtOp,
  input  logic [FW-1:0]      evtFrame,
  input  logic [SW-1:0]      evtSlot,
  input  logic               evtWritable,
  input  logic               clrModValid,
  input  logic [FW-1:0]      clrModFrame,
  input  logic               clrUseValid,
  input  logic [FW-1:0]      clrUseFrame,
  output logic               respValid,
  output logic               respRw,
  output logic               respProtErr,
  output logic [FRAMES-1:0]  modBits,
  output logic [FRAMES-1:0]  useBits,
  output logic [ENTRIES-1:0] tlbValid,
  output logic [ENTRIES-1:0] tlbRw
);
  cmOp_e     op;
  cmStrobe_t st;
  logic curMod, curWr, slotValid, slotRw, clrModSame, clrUseSame;

  assign op = cmOp_e'(evtOp);

  cmCtrl ctrl (
    .op(op), .evtWritable(evtWritable), .curMod(curMod), .curWr(curWr),
    .slotValid(slotValid), .slotRw(slotRw),
    .clrModValid(clrModValid), .clrUseValid(clrUseValid),
    .clrModSame(clrModSame), .clrUseSame(clrUseSame), .st(st)
  );

  cmData #(.FRAMES(FRAMES), .ENTRIES(ENTRIES)) data (
    .clk(clk), .rstN(rstN), .op(op), .evtFrame(evtFrame), .evtSlot(evtSlot),
    .evtWritable(evtWritable), .clrModFrame(clrModFrame),
    .clrUseFrame(clrUseFrame), .st(st),
    .curMod(curMod), .curWr(curWr), .slotValid(slotValid), .slotRw(slotRw),
    .clrModSame(clrModSame), .clrUseSame(clrUseSame),
    .respValid(respValid), .respRw(respRw), .respProtErr(respProtErr),
    .modBits(modBits), .useBits(useBits), .tlbValid(tlbValid), .tlbRw(tlbRw)
  );
endmodule

// File: rtl/cmTrackChk.sv
module cmTrackChk #(
  parameter int FRAMES  = 8,
  parameter int ENTRIES = 4,
  localparam int FW = $clog2(FRAMES),
  localparam int SW = $clog2(ENTRIES)
) (
  input logic               clk,
  input logic               rstN,
  input logic [1:0]         evtOp,
  input logic [FW-1:0]      evtFrame,
  input logic [SW-1:0]      evtSlot,
  input logic               evtWritable,
  input logic               clrModValid,
  input logic [FW-1:0]      clrModFrame,
  input logic               clrUseValid,
  input logic [FW-1:0]      clrUseFrame,
  input logic               respValid,
  input logic               respRw,
  input logic               respProtErr,
  input logic [FRAMES-1:0]  modBits,
  input logic [FRAMES-1:0]  useBits,
  input logic [ENTRIES-1:0] tlbValid,
  input logic [ENTRIES-1:0] tlbRw
);
  assert_clean_read_ro_R2: assert property (@(posedge clk) disable iff (!rstN)
    (evtOp == 2'd1 && !modBits[evtFrame]) |=> (respValid && !respRw));

  assert_write_miss_rw_R3: assert property (@(posedge clk) disable iff (!rstN)
    (evtOp == 2'd2 && evtWritable) |=>
      (respValid && respRw && modBits[$past(evtFrame)] && useBits[$past(evtFrame)]));

  assert_prot_excl_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(respProtErr && respValid));

  assert_clr_mod_R8: assert property (@(posedge clk) disable iff (!rstN)
    (clrModValid && evtOp == 2'd0) |=> !modBits[$past(clrModFrame)]);

  assert_clr_use_R9: assert property (@(posedge clk) disable iff (!rstN)
    (clrUseValid && evtOp == 2'd0) |=> !useBits[$past(clrUseFrame)]);

  assert_mod_exact_R11: assert property (@(posedge clk) disable iff (!rstN)
    !(evtOp == 2'd2 || evtOp == 2'd3) |=> ((modBits & ~$past(modBits)) == '0));
endmodule

bind cmTrack cmTrackChk #(.FRAMES(FRAMES), .ENTRIES(ENTRIES)) chkInst (.*);

// File: tb/cmTrack_test.sv
module cmTrack_test;
  localparam int FRAMES = 8, ENTRIES = 4, FW = 3, SW = 2;

  logic clk = 1'b0, rstN = 1'b0;
  logic [1:0] evtOp = '0;
  logic [FW-1:0] evtFrame = '0, clrModFrame = '0, clrUseFrame = '0;
  logic [SW-1:0] evtSlot = '0;
  logic evtWritable = 1'b0, clrModValid = 1'b0, clrUseValid = 1'b0;
  logic respValid, respRw, respProtErr;
  logic [FRAMES-1:0] modBits, useBits;
  logic [ENTRIES-1:0] tlbValid, tlbRw;

  int nChk = 0, nBad = 0;

  logic [FRAMES-1:0] mm = '0, mu = '0, mw = '0;
  logic [ENTRIES-1:0] tv = '0, trw = '0;
  logic [FW-1:0] tf [ENTRIES];
  logic eRv, eRw, ePe;

  always #10 clk = ~clk;

  cmTrack #(.FRAMES(FRAMES), .ENTRIES(ENTRIES)) uut (.*);

  task automatic cmp(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll(input string tag);
    cmp(tag, "resp", {5'd0, respValid, respRw, respProtErr}, {5'd0, eRv, eRw, ePe});
    cmp(tag, "mod", 8'(modBits), 8'(mm));
    cmp(tag, "use", 8'(useBits), 8'(mu));
    cmp(tag, "tlbV", 8'(tlbValid), 8'(tv));
    cmp(tag, "tlbRw", 8'(tlbRw), 8'(trw));
  endtask

  // Called at a falling edge; presents one cycle of stimulus and checks after the next rise.
  task automatic step(input string tag, input logic [1:0] op, input int f, input int s,
                      input logic w, input logic cmv, input int cmf,
                      input logic cuv, input int cuf);
    logic [FW-1:0] ef;
    logic act, ok;
    evtOp = op; evtFrame = FW'(f); evtSlot = SW'(s); evtWritable = w;
    clrModValid = cmv; clrModFrame = FW'(cmf); clrUseValid = cuv; clrUseFrame = FW'(cuf);
    ef  = (op == 2'd3) ? tf[s] : FW'(f);
    act = (op != 2'd0);
    eRv = 0; eRw = 0; ePe = 0; ok = 0;
    case (op)
      2'd1: begin eRv = 1; eRw = w & mm[f]; end
      2'd2: if (w) begin eRv = 1; eRw = 1; end else ePe = 1;
      2'd3: if (tv[s] && !trw[s]) begin
              if (mw[ef]) begin eRv = 1; eRw = 1; ok = 1; end else ePe = 1;
            end
      default: ;
    endcase
    if (cmv && !(act && FW'(cmf) == ef)) begin
      mm[cmf] = 0;
      for (int e = 0; e < ENTRIES; e++) if (tf[e] == FW'(cmf)) trw[e] = 0;
    end
    if (cuv && !(act && FW'(cuf) == ef)) begin
      mu[cuf] = 0;
      for (int e = 0; e < ENTRIES; e++) if (tf[e] == FW'(cuf)) tv[e] = 0;
    end
    if (op == 2'd1) begin
      mu[f] = 1; mw[f] = w; tv[s] = 1; tf[s] = FW'(f); trw[s] = eRw;
    end else if (op == 2'd2 && w) begin
      mm[f] = 1; mu[f] = 1; mw[f] = 1; tv[s] = 1; tf[s] = FW'(f); trw[s] = 1;
    end else if (ok) begin
      mm[ef] = 1; mu[ef] = 1; trw[s] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    evtOp = 0; clrModValid = 0; clrUseValid = 0;
    checkAll(tag);
  endtask

  initial begin
    for (int e = 0; e < ENTRIES; e++) tf[e] = '0;
    eRv = 0; eRw = 0; ePe = 0;
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    @(negedge clk);
    checkAll("R1");

    // R2: read misses on every clean frame, alternating true permission
    for (int f = 0; f < FRAMES; f++) step("R2", 2'd1, f, f % ENTRIES, f[0], 0, 0, 0, 0);
    // R3 on writable frames, R4 on protected frames
    for (int f = 0; f < FRAMES; f++)
      step(f[0] ? "R3" : "R4", 2'd2, f, f % ENTRIES, f[0], 0, 0, 0, 0);
    // R2: dirty writable frames reload read-write
    for (int f = 1; f < FRAMES; f += 2) step("R2", 2'd1, f, f % ENTRIES, 1'b1, 0, 0, 0, 0);

    // R8: writeback clears frame 7 (in slot 3), slot becomes read-only
    step("R8", 2'd0, 0, 0, 0, 1, 7, 0, 0);
    // R5: first store to the cleaned page upgrades it
    step("R5", 2'd3, 0, 3, 0, 0, 0, 0, 0);
    // R7: a second fault on the now read-write slot does nothing
    step("R7", 2'd3, 0, 3, 0, 0, 0, 0, 0);
    // R6: truly read-only frame 2 in slot 2 faults with a protection error
    step("R2", 2'd1, 2, 2, 1'b0, 0, 0, 0, 0);
    step("R6", 2'd3, 0, 2, 0, 0, 0, 0, 0);
    // R9: sweeper clears frame 5 (slot 1); then a fault on the invalid slot is ignored
    step("R9", 2'd0, 0, 0, 0, 0, 0, 1, 5);
    step("R7", 2'd3, 0, 1, 0, 0, 0, 0, 0);

    // R8, R9: clears over all frames
    for (int f = 0; f < FRAMES; f++) step("R8", 2'd0, 0, 0, 0, 1, f, 0, 0);
    for (int f = 0; f < FRAMES; f++) step("R9", 2'd0, 0, 0, 0, 0, 0, 1, f);

    // R10: same-frame collisions drop the clears; different frame still clears
    step("R10", 2'd2, 5, 1, 1'b1, 1, 5, 1, 5);
    step("R3", 2'd2, 6, 2, 1'b1, 0, 0, 0, 0);
    step("R10", 2'd2, 3, 3, 1'b1, 1, 6, 1, 6);
    step("R10", 2'd1, 3, 0, 1'b1, 1, 3, 0, 0);
    step("R10", 2'd0, 0, 0, 0, 1, 3, 0, 0);
    step("R5", 2'd3, 0, 3, 0, 0, 0, 0, 0);
    // R11: idle cycles keep every modified bit where it was
    step("R11", 2'd0, 0, 0, 0, 0, 0, 0, 0);
    step("R11", 2'd1, 4, 0, 1'b1, 0, 0, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    nChk++; nBad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule